// File: doc/BRIEF.md
# Self-ID Receive Buffer Controller

After a bus reset, the node sees a burst of self-ID quadlets. This block writes that burst into a host memory buffer, one quadlet after another. Software programs the buffer base through a pointer register. The base must sit on a 2-Kbyte boundary. A status register reports three things: a wrapping 8-bit count of bus resets, the number of quadlets the host has accepted in the current reception, and a sticky error flag.

The quadlet stream marks a reception with start and end strobes. Between them it carries data beats and an error strobe. The memory side issues one write at a time with valid/ready handshaking and takes an error response. While a write waits for ready, the stream is stalled through `sid_ready`. The write address for quadlet n is the base sampled at start plus 4·n. Writing never leaves the 2-Kbyte window.

Top module: `selfid_rx_buffer`

## Requirements
- R1: The pointer register sits at byte offset 0x64. Register writes update bits 31..11. Bits 10..0 always read as zero.
- R2: The status register sits at offset 0x68 and has this layout: bit 31 error flag, bits 23..16 generation, bits 10..2 size. Every other bit reads zero. Register writes to 0x68 have no effect. Reads from any other offset return zero.
- R3: The generation field goes up by one on every `bus_reset` pulse and wraps from 255 to 0.
- R4: An accepted start strobe clears the size field to zero. Each host-accepted write then adds one to it.
- R5: Quadlet n of a reception is written to address base + 4·n. The base is the pointer value sampled at the start strobe. A pointer write during the reception does not change the current addresses.
- R6: While a memory write is pending, `sid_ready` is low, and address and data stay stable. The size field changes only when `mem_ready` accepts the write.
- R7: The error flag is set when `sid_error` pulses during a reception, or when an accepted write returns `mem_err`.
- R8: A start strobe does not clear the error flag. The flag is cleared when a reception ends with no error detected since its start. Otherwise it stays set.
- R9: Size stops at 511. A data beat that arrives when size is 511 issues no write and sets the error flag.
- R10: After reset, the pointer, generation, size and error flag all read zero, and `sid_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| bus_reset | input | 1 | One-cycle pulse per detected bus reset |
| sid_start | input | 1 | Reception start strobe |
| sid_valid | input | 1 | Quadlet data beat |
| sid_data | input | 32 | Quadlet value |
| sid_end | input | 1 | Reception end strobe |
| sid_error | input | 1 | Stream error strobe |
| sid_ready | output | 1 | Stream may advance; low while a write is pending |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| mem_err | input | 1 | Error response, qualified by mem_ready |

## Verification
The assertions assume three things about the stream. Start, beat and end strobes count only in cycles where `sid_ready` is high. At most one of them is raised at a time. `mem_err` has meaning only when it comes with `mem_ready` on a pending write. The bench drives every strobe for one cycle from a negedge, and only when the block is idle or has just retired its write. It raises `mem_ready` only after it has seen `mem_valid`, and only then drives `mem_err`, so stimulus never leaves these bounds.

// File: rtl/sidbuf_pkg.sv
package sidbuf_pkg;
  localparam int ALIGN_W  = 11;
  localparam int SIZE_W   = 9;
  localparam int GEN_W    = 8;
  localparam int REG_AW   = 8;
  localparam logic [REG_AW-1:0] PTR_OFS  = 8'h64;
  localparam logic [REG_AW-1:0] STAT_OFS = 8'h68;

  function automatic logic [31:0] quad_addr(input logic [31-ALIGN_W:0] base,
                                            input logic [SIZE_W-1:0]    idx);
    return {base, {ALIGN_W{1'b0}}} + (32'(idx) << 2);
  endfunction

  function automatic logic [31:0] pack_status(input logic              err,
                                              input logic [GEN_W-1:0]  gen,
                                              input logic [SIZE_W-1:0] size);
    return {err, 7'b0, gen, 5'b0, size, 2'b0};
  endfunction
endpackage

// File: rtl/sidbuf_regs.sv
module sidbuf_regs
  import sidbuf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  bus_reset,
  input  logic                  err_flag,
  input  logic [SIZE_W-1:0]     size_cnt,
  output logic [31-ALIGN_W:0]   base_hi
);
  localparam logic [GEN_W-1:0] GEN_ONE = {{(GEN_W-1){1'b0}}, 1'b1};

  logic [31-ALIGN_W:0] ptr_q;
  logic [GEN_W-1:0]    gen_q;
  logic                ptr_wr;

  assign ptr_wr  = reg_we && (reg_addr == PTR_OFS);
  assign base_hi = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      gen_q <= '0;
    end else begin
      if (ptr_wr)    ptr_q <= reg_wdata[31:ALIGN_W];
      if (bus_reset) gen_q <= gen_q + GEN_ONE;
    end
  end

  always_comb begin
    case (reg_addr)
      PTR_OFS:  reg_rdata = {ptr_q, {ALIGN_W{1'b0}}};
      STAT_OFS: reg_rdata = pack_status(err_flag, gen_q, size_cnt);
      default:  reg_rdata = '0;
    endcase
  end

  always_comb begin
    if (rst_n && reg_addr == PTR_OFS)
      AST_PTR_LOW_ZERO: assert (reg_rdata[ALIGN_W-1:0] == '0); // R1
  end

  AST_GEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> gen_q == $past(gen_q) + GEN_ONE); // R3
  AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_reset |=> $stable(gen_q)); // R3
endmodule

// File: rtl/sidbuf_writer.sv
module sidbuf_writer
  import sidbuf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31-ALIGN_W:0] base_hi,
  input  logic                sid_start,
  input  logic                sid_valid,
  input  logic [31:0]         sid_data,
  input  logic                sid_end,
  input  logic                sid_error,
  output logic                sid_ready,
  output logic                mem_valid,
  output logic [31:0]         mem_addr,
  output logic [31:0]         mem_data,
  input  logic                mem_ready,
  input  logic                mem_err,
  output logic                err_flag,
  output logic [SIZE_W-1:0]   size_cnt
);
  localparam logic [SIZE_W-1:0] SIZE_MAX = '1;
  localparam logic [SIZE_W-1:0] SIZE_ONE = {{(SIZE_W-1){1'b0}}, 1'b1};

  logic                active_q, pend_q, err_q, run_err_q;
  logic [31-ALIGN_W:0] base_q;
  logic [SIZE_W-1:0]   size_q;
  logic [31:0]         addr_q, data_q;

  // named events for the checks below
  logic start_evt, beat_evt, end_evt, full, issue_evt, drop_evt;
  logic done_evt, werr_evt, err_evt, clean_end;

  assign sid_ready = !pend_q;
  assign start_evt = sid_start && sid_ready;
  assign beat_evt  = active_q && sid_valid && sid_ready && !sid_start;
  assign end_evt   = active_q && sid_end && sid_ready && !sid_start;
  assign full      = (size_q == SIZE_MAX);
  assign issue_evt = beat_evt && !full;
  assign drop_evt  = beat_evt && full;
  assign done_evt  = pend_q && mem_ready;
  assign werr_evt  = done_evt && mem_err;
  assign err_evt   = (active_q && sid_error) || werr_evt || drop_evt;
  assign clean_end = end_evt && !run_err_q && !err_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      pend_q    <= 1'b0;
      err_q     <= 1'b0;
      run_err_q <= 1'b0;
      base_q    <= '0;
      size_q    <= '0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      if (start_evt) begin
        active_q  <= 1'b1;
        base_q    <= base_hi;
        size_q    <= '0;
        run_err_q <= 1'b0;
      end else begin
        if (done_evt) size_q <= size_q + SIZE_ONE;
        if (err_evt)  run_err_q <= 1'b1;
        if (end_evt)  active_q <= 1'b0;
      end
      if (issue_evt) begin
        pend_q <= 1'b1;
        addr_q <= quad_addr(base_q, size_q);
        data_q <= sid_data;
      end else if (done_evt) begin
        pend_q <= 1'b0;
      end
      if (err_evt)        err_q <= 1'b1;
      else if (clean_end) err_q <= 1'b0;
    end
  end

  assign mem_valid = pend_q;
  assign mem_addr  = addr_q;
  assign mem_data  = data_q;
  assign err_flag  = err_q;
  assign size_cnt  = size_q;

  AST_ADDR_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[31:ALIGN_W] == base_q) && (mem_addr[1:0] == 2'b00)); // R5
  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !sid_ready); // R6
  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R6
  AST_SIZE_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt && !done_evt |=> $stable(size_q)); // R6
  AST_SIZE_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> size_q == '0); // R4
  AST_ERR_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err_flag); // R7
  AST_START_KEEPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && err_flag |=> err_flag); // R8
  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !mem_valid && err_flag); // R9

  always_comb begin
    if (rst_n) AST_NO_OVERFLOW: assert (!(full && issue_evt)); // R9
  end
endmodule

// File: rtl/selfid_rx_buffer.sv
module selfid_rx_buffer
  import sidbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              bus_reset,
  input  logic              sid_start,
  input  logic              sid_valid,
  input  logic [31:0]       sid_data,
  input  logic              sid_end,
  input  logic              sid_error,
  output logic              sid_ready,
  output logic              mem_valid,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_data,
  input  logic              mem_ready,
  input  logic              mem_err
);
  logic [31-ALIGN_W:0] base_hi;
  logic                err_flag;
  logic [SIZE_W-1:0]   size_cnt;

  sidbuf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_reset(bus_reset),
    .err_flag(err_flag), .size_cnt(size_cnt), .base_hi(base_hi)
  );

  sidbuf_writer u_writer (
    .clk(clk), .rst_n(rst_n), .base_hi(base_hi),
    .sid_start(sid_start), .sid_valid(sid_valid), .sid_data(sid_data),
    .sid_end(sid_end), .sid_error(sid_error), .sid_ready(sid_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready), .mem_err(mem_err),
    .err_flag(err_flag), .size_cnt(size_cnt)
  );

  AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == STAT_OFS) |-> (reg_rdata[30:24] == '0) && (reg_rdata[15:11] == '0)
                             && (reg_rdata[1:0] == '0)); // R2
endmodule

// File: tb/selfid_rx_buffer_bench.sv
module selfid_rx_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_reset = 1'b0;
  logic        sid_start = 1'b0, sid_valid = 1'b0, sid_end = 1'b0, sid_error = 1'b0;
  logic [31:0] sid_data = '0;
  logic        sid_ready, mem_valid;
  logic [31:0] mem_addr, mem_data;
  logic        mem_ready = 1'b0, mem_err = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_base;
  int          exp_n;

  always #2.5 clk = ~clk;

  selfid_rx_buffer u_selfid_rx_buffer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_reset(bus_reset),
    .sid_start(sid_start), .sid_valid(sid_valid), .sid_data(sid_data),
    .sid_end(sid_end), .sid_error(sid_error), .sid_ready(sid_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready), .mem_err(mem_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] stat(input logic e, input logic [7:0] g, input int sz);
    logic [8:0] s9;
    s9 = 9'(sz);
    return (32'(e) << 31) | (32'(g) << 16) | (32'(s9) << 2);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic strobe_start();
    @(negedge clk); sid_start = 1'b1;
    @(negedge clk); sid_start = 1'b0;
    exp_n = 0;
  endtask

  task automatic strobe_end();
    @(negedge clk); sid_end = 1'b1;
    @(negedge clk); sid_end = 1'b0;
  endtask

  task automatic pulse_reset(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); bus_reset = 1'b1;
      @(negedge clk); bus_reset = 1'b0;
    end
  endtask

  // one quadlet; exp_write=0 means a dropped beat is expected
  task automatic send_quad(input logic [31:0] d, input int waits, input logic merr,
                           input logic exp_write);
    logic [31:0] st_before, st;
    @(negedge clk); sid_valid = 1'b1; sid_data = d;
    @(negedge clk); sid_valid = 1'b0;
    if (!exp_write) begin
      chk("R9 dropped beat issues no write", 32'(mem_valid), 32'd0);
      return;
    end
    chk("R5 write issued", 32'(mem_valid), 32'd1);
    chk("R5 write address", mem_addr, exp_base + 32'(exp_n) * 32'd4);
    chk("R5 write data", mem_data, d);
    rd(8'h68, st_before);
    for (int w = 0; w < waits; w++) begin
      chk("R6 stream stalled", 32'(sid_ready), 32'd0);
      rd(8'h68, st);
      chk("R6 size waits for accept", st, st_before);
      @(negedge clk);
      chk("R6 address stable", mem_addr, exp_base + 32'(exp_n) * 32'd4);
    end
    mem_ready = 1'b1; mem_err = merr;
    @(negedge clk); mem_ready = 1'b0; mem_err = 1'b0;
    chk("R6 write retired", 32'(mem_valid), 32'd0);
    exp_n++;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h64, d); chk("R10 pointer after reset", d, 32'h0);
    rd(8'h68, d); chk("R10 status after reset", d, 32'h0);
    chk("R10 ready after reset", 32'(sid_ready), 32'd1);
    chk("R10 no write after reset", 32'(mem_valid), 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h64, 32'hFFFF_FFFF);
    rd(8'h64, d); chk("R1 low bits read zero", d, 32'hFFFF_F800);
    wr(8'h64, 32'h1234_5ABC);
    rd(8'h64, d); chk("R1 pointer write", d, 32'h1234_5800);
    wr(8'h68, 32'hFFFF_FFFF);
    rd(8'h68, d); chk("R2 status write ignored", d, 32'h0);
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, d); chk("R2 other offset reads zero", d, 32'h0);
    rd(8'h64, d); chk("R2 stray write ignored", d, 32'h1234_5800);
  endtask

  task automatic t_gen();
    logic [31:0] d;
    pulse_reset(3);
    rd(8'h68, d); chk("R3 generation counts", d, stat(1'b0, 8'd3, 0));
    pulse_reset(252);
    rd(8'h68, d); chk("R3 generation at 255", d, stat(1'b0, 8'd255, 0));
    pulse_reset(1);
    rd(8'h68, d); chk("R3 generation wraps", d, stat(1'b0, 8'd0, 0));
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(8'h64, 32'h0001_0800); exp_base = 32'h0001_0800;
    strobe_start();
    rd(8'h68, d); chk("R4 size cleared at start", d, stat(1'b0, 8'd0, 0));
    send_quad(32'hA000_0001, 0, 1'b0, 1'b1);
    send_quad(32'hA000_0002, 3, 1'b0, 1'b1);
    wr(8'h64, 32'h0002_0000);
    send_quad(32'hA000_0003, 1, 1'b0, 1'b1);
    rd(8'h68, d); chk("R4 size counts accepted", d, stat(1'b0, 8'd0, 3));
    strobe_end();
    rd(8'h68, d); chk("R8 clean end no error", d, stat(1'b0, 8'd0, 3));
    exp_base = 32'h0002_0000;
    strobe_start();
    rd(8'h68, d); chk("R4 size cleared again", d, stat(1'b0, 8'd0, 0));
    send_quad(32'hB000_0001, 0, 1'b0, 1'b1);
    strobe_end();
  endtask

  task automatic t_errors();
    logic [31:0] d;
    strobe_start();
    send_quad(32'hC1, 0, 1'b0, 1'b1);
    @(negedge clk); sid_error = 1'b1;
    @(negedge clk); sid_error = 1'b0;
    rd(8'h68, d); chk("R7 stream error sets flag", d, stat(1'b1, 8'd0, 1));
    strobe_end();
    rd(8'h68, d); chk("R8 flag stays after errored end", d[31:0], stat(1'b1, 8'd0, 1));
    strobe_start();
    rd(8'h68, d); chk("R8 start keeps flag", d, stat(1'b1, 8'd0, 0));
    send_quad(32'hC2, 0, 1'b0, 1'b1);
    strobe_end();
    rd(8'h68, d); chk("R8 clean end clears flag", d, stat(1'b0, 8'd0, 1));
    strobe_start();
    send_quad(32'hC3, 2, 1'b1, 1'b1);
    rd(8'h68, d); chk("R7 write error sets flag", d, stat(1'b1, 8'd0, 1));
    send_quad(32'hC4, 0, 1'b0, 1'b1);
    strobe_end();
    rd(8'h68, d); chk("R8 write error survives end", d, stat(1'b1, 8'd0, 2));
    strobe_start(); strobe_end();
    rd(8'h68, d); chk("R8 empty clean reception clears", d, stat(1'b0, 8'd0, 0));
  endtask

  task automatic t_capacity();
    logic [31:0] d;
    strobe_start();
    for (int i = 0; i < 511; i++) send_quad(32'hD000_0000 + 32'(i), 0, 1'b0, 1'b1);
    rd(8'h68, d); chk("R9 size at 511 no error", d, stat(1'b0, 8'd0, 511));
    send_quad(32'hDEAD_BEEF, 0, 1'b0, 1'b0);
    rd(8'h68, d); chk("R9 overflow sets flag, size held", d, stat(1'b1, 8'd0, 511));
    strobe_end();
    rd(8'h68, d); chk("R9 overflow flag survives end", d, stat(1'b1, 8'd0, 511));
  endtask

  initial begin
    exp_base = '0; exp_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_gen();
    t_basic();
    t_errors();
    t_capacity();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule